// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM with Split Data Buses

This block is a synthesizable behavioural model of a synchronous static memory. It has a separate write-data bus and read-data bus. Each access moves two data beats, one on each half of a clock period. On every rising edge of `clk` the block samples an active-low strobe and a direction select. Together they pick one of three operations: idle, read or write. The falling phase is represented by a second clock input, `clk_inv`, which is the complement of `clk`. With both clocks, every storage element is an ordinary rising-edge flop.

A write takes its first beat from `wdata` at the `clk` edge that samples the command. It takes the second beat at the next `clk_inv` edge. A read presents its two beats during the clock period after the command: the first beat while `clk` is high and the second beat while `clk` is low.

The read-data drive enable is high exactly for the period after a read. An idle or write command therefore drops it one period after that command is sampled. A read that comes just before such a command still gets its period of driven data. Two echo clocks follow `clk` and `clk_inv` at all times, whatever the drive enable is doing. The array holds 256 burst pairs of 16-bit beats, and each address selects one pair.

Top module: `ddr2b_sram`

## Requirements
- R1: With `strobe_n`=1 the command is idle: `rd_wr`, `addr` and `wdata` have no effect, and no stored pair changes.
- R2: With `strobe_n`=0 and `rd_wr`=1, the pair stored at `addr` is read and appears on `rdata` in the following clock period.
- R3: In the period that carries read data, beat 0 is on `rdata` while `clk` is high and beat 1 is on `rdata` while `clk` is low.
- R4: With `strobe_n`=0 and `rd_wr`=0, the value of `wdata` at the `clk` rising edge is stored as beat 0 of the pair at `addr`. The value of `wdata` at the following `clk_inv` rising edge is stored as beat 1.
- R5: `rdata_oe` is 1 during the period after a read command and 0 during the period after an idle or write command. While `rdata_oe` is 0, `rdata` is all zeros.
- R6: A read followed at once by an idle or write command still drives its two beats. `rdata_oe` falls only in the period after the later command.
- R7: A read issued in the period right after a write to the same address returns the newly written pair.
- R8: `echo_clk` always equals `clk` and `echo_clk_inv` always equals `clk_inv`, independent of the command stream.
- R9: While `rst` is high and in the period after it is released, `rdata_oe` is 0 and `rdata` is zero.
- R10: Pairs at different addresses, including the lowest and highest address, are stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; commands, address and beat 0 sampled on its rising edge |
| clk_inv | input | 1 | Complement of `clk`; beat 1 of a write sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Active-low command strobe; high means idle |
| rd_wr | input | 1 | Direction select: 1 read, 0 write |
| addr | input | 8 | Burst pair address |
| wdata | input | 16 | Write data bus, two beats per write |
| rdata | output | 16 | Read data bus, two beats per read |
| rdata_oe | output | 1 | Read-data drive enable for the pad tristate |
| echo_clk | output | 1 | Echo of `clk`, always driven |
| echo_clk_inv | output | 1 | Echo of `clk_inv`, always driven |

## Verification
The bench puts an idle, and then a write, directly after a read. A design that switches the drive enable off on the command itself, instead of one period later, would cut off that read's beats.

It issues a read in the period right after a write to the same address. An array commit that lands one edge late would return the old pair.

It sends an idle cycle with write-like direction, address and data, then reads that address back. Strobe decoding that ignores the strobe would overwrite the pair.

It checks each beat in its own half-period, at the lowest and highest address. Swapped beats, or beat 1 captured on the wrong clock, show up as mismatched halves.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    // Number of data beats carried by one access
    localparam int unsigned BEATS = 2;

    // Decoded command held for one period after sampling
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Strobe high means idle; otherwise the direction select chooses
    function automatic op_e decode_op(input logic strobe_n, input logic rd_wr);
        if (strobe_n) begin
            return OP_IDLE;
        end
        return rd_wr ? OP_READ : OP_WRITE;
    endfunction

    // Which beat a half-period carries, from the two phase toggles
    function automatic logic first_half(input logic ph_rise, input logic ph_fall);
        return ph_rise ^ ph_fall;
    endfunction

endpackage

// File: rtl/ddr2b_cmd_stage.sv
module ddr2b_cmd_stage
    import ddr2b_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         clk_inv,
    input  logic                         rst,
    input  logic                         strobe_n,
    input  logic                         rd_wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output op_e                          op_q,
    output logic [ADDR_W-1:0]            addr_q,
    output logic [BEATS-1:0][DATA_W-1:0] wpair_q
);

    op_e               op_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] beat_rise_r;
    logic [DATA_W-1:0] beat_fall_r;

    // Command, address and beat 0 on the main rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            op_r        <= OP_IDLE;
            addr_r      <= '0;
            beat_rise_r <= '0;
        end else begin
            op_r        <= decode_op(strobe_n, rd_wr);
            addr_r      <= addr;
            beat_rise_r <= wdata;
        end
    end

    // Beat 1 on the complementary clock, mid-period
    always_ff @(posedge clk_inv) begin
        if (rst) begin
            beat_fall_r <= '0;
        end else begin
            beat_fall_r <= wdata;
        end
    end

    assign op_q       = op_r;
    assign addr_q     = addr_r;
    assign wpair_q[0] = beat_rise_r;
    assign wpair_q[1] = beat_fall_r;

endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array
    import ddr2b_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            idx,
    input  logic [BEATS-1:0][DATA_W-1:0] wpair,
    output logic [BEATS-1:0][DATA_W-1:0] rpair
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    // One bank per beat, sharing the index
    for (genvar b = 0; b < BEATS; b++) begin : g_bank
        logic [DATA_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                bank[idx] <= wpair[b];
            end
        end

        assign rpair[b] = bank[idx];
    end

endmodule

// File: rtl/ddr2b_rd_stage.sv
module ddr2b_rd_stage
    import ddr2b_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         clk_inv,
    input  logic                         rst,
    input  logic                         load,
    input  logic [BEATS-1:0][DATA_W-1:0] rpair,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rdata_oe
);

    logic [BEATS-1:0][DATA_W-1:0] pair_r;
    logic                         oe_r;
    logic                         ph_rise_r;
    logic                         ph_fall_r;
    logic                         beat_sel;

    // The drive enable follows the previous period's command
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_r    <= '0;
            oe_r      <= 1'b0;
            ph_rise_r <= 1'b0;
        end else begin
            oe_r      <= load;
            ph_rise_r <= ~ph_rise_r;
            if (load) begin
                pair_r <= rpair;
            end
        end
    end

    always_ff @(posedge clk_inv) begin
        if (rst) begin
            ph_fall_r <= 1'b0;
        end else begin
            ph_fall_r <= ph_rise_r;
        end
    end

    // The toggles differ only between a rise and the next fall
    assign beat_sel = ~first_half(ph_rise_r, ph_fall_r);

    always_comb begin
        rdata = '0;
        if (oe_r) begin
            rdata = pair_r[beat_sel];
        end
    end

    assign rdata_oe = oe_r;

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              clk_inv,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              echo_clk,
    output logic              echo_clk_inv
);

    op_e                          op_q;
    logic [ADDR_W-1:0]            addr_q;
    logic [BEATS-1:0][DATA_W-1:0] wpair_q;
    logic [BEATS-1:0][DATA_W-1:0] rpair;
    logic                         mem_we;
    logic                         rd_load;

    ddr2b_cmd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmd_i (
        .clk      (clk),
        .clk_inv  (clk_inv),
        .rst      (rst),
        .strobe_n (strobe_n),
        .rd_wr    (rd_wr),
        .addr     (addr),
        .wdata    (wdata),
        .op_q     (op_q),
        .addr_q   (addr_q),
        .wpair_q  (wpair_q)
    );

    assign mem_we  = (op_q == OP_WRITE);
    assign rd_load = (op_q == OP_READ);

    ddr2b_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk   (clk),
        .we    (mem_we),
        .idx   (addr_q),
        .wpair (wpair_q),
        .rpair (rpair)
    );

    ddr2b_rd_stage #(.DATA_W(DATA_W)) rd_i (
        .clk      (clk),
        .clk_inv  (clk_inv),
        .rst      (rst),
        .load     (rd_load),
        .rpair    (rpair),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    // Echo clocks have no enable path
    assign echo_clk     = clk;
    assign echo_clk_inv = clk_inv;

endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_n,
    input logic              rd_wr,
    input logic              rdata_oe,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_we
);

    // R5
    oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(!strobe_n && rd_wr, 2)) |-> rdata_oe);

    // R5
    oe_off_after_other_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(strobe_n || !rd_wr, 2)) |-> !rdata_oe);

    // R5
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rdata_oe && rdata == '0));

    // R1
    no_write_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe_n)) |-> !mem_we);

    // R4
    write_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!strobe_n && !rd_wr)) |-> mem_we);

endmodule

bind ddr2b_sram ddr2b_sram_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .rd_wr    (rd_wr),
    .rdata_oe (rdata_oe),
    .rdata    (rdata),
    .mem_we   (mem_we)
);

// File: tb/ddr2b_sram_tb_top.sv
module ddr2b_sram_tb_top;

    logic        clk = 1'b0;
    logic        clk_inv = 1'b1;
    logic        rst = 1'b1;
    logic        strobe_n = 1'b1;
    logic        rd_wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdata_oe;
    logic        echo_clk;
    logic        echo_clk_inv;

    int errors = 0;
    int checks = 0;
    bit go = 0;
    bit done = 0;

    typedef struct {
        logic        oe;
        logic [15:0] b0;
        logic [15:0] b1;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mdl0 [256];
    logic [15:0] mdl1 [256];

    // 50 MHz: 20 ns period, complementary clock in the same process
    always #10 begin
        clk     = ~clk;
        clk_inv = ~clk_inv;
    end

    ddr2b_sram dut_i (
        .clk          (clk),
        .clk_inv      (clk_inv),
        .rst          (rst),
        .strobe_n     (strobe_n),
        .rd_wr        (rd_wr),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .rdata_oe     (rdata_oe),
        .echo_clk     (echo_clk),
        .echo_clk_inv (echo_clk_inv)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: called at 12 ns into a period; returns 12 ns into the next
    task automatic issue(input logic s_n, input logic rw, input logic [7:0] a,
                         input logic [15:0] d0, input logic [15:0] d1, input string tag);
        exp_t e;
        strobe_n = s_n;
        rd_wr    = rw;
        addr     = a;
        wdata    = d0;
        if (!s_n && rw) begin
            e.oe = 1'b1; e.b0 = mdl0[a]; e.b1 = mdl1[a];
        end else begin
            e.oe = 1'b0; e.b0 = '0; e.b1 = '0;
        end
        e.tag = tag;
        if (!s_n && !rw) begin
            mdl0[a] = d0;
            mdl1[a] = d1;
        end
        sb.push_back(e);
        @(posedge clk);
        go = 1;
        #2 wdata = d1;
        #10;
    endtask

    // Monitor: pops one expected item per period after each command
    initial begin
        logic [15:0] s0, s1;
        logic        o0, o1;
        exp_t        e;
        wait (go);
        forever begin
            @(posedge clk);
            #3;
            s0 = rdata; o0 = rdata_oe;
            check(echo_clk == 1'b1 && echo_clk_inv == 1'b0, "R8", {echo_clk, echo_clk_inv}, 2'b10);
            #10;
            s1 = rdata; o1 = rdata_oe;
            check(echo_clk == 1'b0 && echo_clk_inv == 1'b1, "R8", {echo_clk, echo_clk_inv}, 2'b01);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(o0 == e.oe && o1 == e.oe, {e.tag, " R5 oe"}, {o0, o1}, {e.oe, e.oe});
                check(s0 == e.b0, {e.tag, " R3 beat0"}, s0, e.b0);
                check(s1 == e.b1, {e.tag, " R3 beat1"}, s1, e.b1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: quiet outputs during reset
        repeat (4) @(posedge clk);
        #3;
        check(rdata_oe == 1'b0, "R9 oe in reset", rdata_oe, 0);
        check(rdata == '0, "R9 data in reset", rdata, 0);
        rst = 0;
        @(posedge clk);
        #9;
        issue(1, 0, 8'h00, 16'h0, 16'h0, "R9 idle after reset");

        // R4, R10: writes at both ends and in the middle
        issue(0, 0, 8'h00, 16'h1111, 16'h2222, "R4 write low");
        issue(0, 0, 8'hFF, 16'hAAAA, 16'h5555, "R4 write high");
        issue(0, 0, 8'h5A, 16'hBEEF, 16'hCAFE, "R4 write mid");
        issue(1, 1, 8'h00, 16'h0, 16'h0, "R5 idle after write");
        // R2, R10: reads back to back
        issue(0, 1, 8'h00, 16'h0, 16'h0, "R2 read low");
        issue(0, 1, 8'hFF, 16'h0, 16'h0, "R10 read high");
        issue(0, 1, 8'h5A, 16'h0, 16'h0, "R2 read mid");
        // R6: idle after read keeps the read beats
        issue(1, 0, 8'h00, 16'h0, 16'h0, "R6 idle after read");
        // R1: idle with write-looking inputs changes nothing
        issue(1, 0, 8'h5A, 16'hDEAD, 16'hF00D, "R1 idle write-like");
        issue(0, 1, 8'h5A, 16'h0, 16'h0, "R1 readback unchanged");
        // R6: write directly after a read
        issue(0, 0, 8'h33, 16'h0123, 16'h4567, "R6 write after read");
        // R7: read directly after a write to the same address
        issue(0, 1, 8'h33, 16'h0, 16'h0, "R7 read after write");
        issue(0, 0, 8'h33, 16'h89AB, 16'hCDEF, "R7 overwrite");
        issue(0, 1, 8'h33, 16'h0, 16'h0, "R7 read new pair");
        issue(0, 1, 8'h00, 16'h0, 16'h0, "R10 low untouched");
        issue(1, 1, 8'hFF, 16'h0, 16'h0, "R5 idle");
        issue(1, 1, 8'h00, 16'h0, 16'h0, "R5 idle");

        repeat (3) @(posedge clk);
        #15;
        check(sb.size() == 0, "R2 all results seen", sb.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule